// File: doc/BRIEF.md
# Frame Cipher Controller

This block sequences one frame of block-cipher work out of a local RAM of 256 blocks, each 128 bits wide (4 KB). After a start pulse it fetches a three-block header from the bottom of the RAM. The header gives the key, a key-size selector, the direction and the number of data blocks. The controller then loads the key into an external iterative cipher datapath and walks the data blocks one after another. Each block is read, handed to the cipher, collected after the cipher's fixed latency and written back over the address it came from. Once `start` is taken, the frame runs to completion with no further handshake from the host. A single `done` pulse marks the end of the frame.

The RAM port and the cipher port are both fixed-latency and carry no back-pressure. RAM reads return data one cycle after `mem_rd_en`. The cipher must raise `cph_done` exactly ten cycles after `cph_start`. Because neither side can stall, each block costs a fixed 13-cycle budget: one read cycle, eleven processing cycles and one write cycle. Header layout: block 0 holds key bits 127:0 and block 1 holds key bits 255:128. Block 2 is the control word, with the key-size code in bits 1:0, the direction in bit 4 and the block count in bits 23:16. Data starts at block 3.

Top module: `frame_cipher_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy`, `done`, `err`, `mem_rd_en`, `mem_wr_en`, `key_load` and `cph_start` are all low.
- R2: The header is read from blocks 0, 1 and 2. `key_sel` presents control bits 1:0 (0 = 128-bit, 1 = 192-bit, 2 = 256-bit key). `decrypt` presents control bit 4 (1 = decrypt). `key_val` presents {block 1, block 0}.
- R3: Each frame with at least one valid block produces exactly one `key_load` pulse, followed by a key phase of 11 cycles in total. This phase completes before the first `cph_start` of the frame.
- R4: Each block takes exactly 13 cycles: a read, a launch with `cph_din` equal to the read data on the next cycle, a wait for `cph_done`, and then a write of `cph_dout`. For N blocks, `done` is high on the cycle after the (16 + 13·N)-th rising edge that follows the edge on which `start` was taken.
- R5: Results overwrite their source addresses, blocks 3 to 3+N-1, and no other RAM address is written. Exactly N writes occur.
- R6: `done` is a single-cycle pulse, given once per frame after the last write.
- R7: A block count of 0 gives `done` on the cycle after the 5th edge following start, with no key load, no write and `err` low.
- R8: Key-size code 3, or a block count above 253, sets `err` and ends the frame with `done` after 5 edges, with no key load and no write. `err` stays high until the next start clears it.
- R9: A `start` pulse while a frame is running is ignored: it changes neither the frame's timing nor its results, and it adds no `done` pulse.
- R10: `mem_rd_en` and `mem_wr_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame when idle |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Bad header seen in the last frame |
| mem_rd_en | output | 1 | RAM read request |
| mem_wr_en | output | 1 | RAM write request |
| mem_addr | output | 8 | RAM block address |
| mem_wdata | output | 128 | RAM write data |
| mem_rdata | input | 128 | RAM read data, one cycle after request |
| key_load | output | 1 | Key load pulse to cipher |
| key_val | output | 256 | Key from header |
| key_sel | output | 2 | Key-size code |
| decrypt | output | 1 | Direction to cipher |
| cph_start | output | 1 | Launch one block |
| cph_din | output | 128 | Block into cipher |
| cph_done | input | 1 | Result valid, ten cycles after launch |
| cph_dout | input | 128 | Block out of cipher |

## Verification
The assertions assume that the cipher returns `cph_done` only in response to a launch and never early, and that RAM read data is valid on the cycle after the request. The bench's RAM model and its add/subtract cipher stand-in respect both rules exactly, with a ten-cycle result counter. Frames are loaded into the RAM model only while the controller is idle, so header contents never change during a frame. A sentinel block just past each frame exposes any write outside the frame.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int HDR_BLKS  = 3;
  localparam int KCODE_LSB = 0;
  localparam int KCODE_W   = 2;
  localparam int MODE_BIT  = 4;
  localparam int LEN_LSB   = 16;
  localparam int LEN_W     = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DEC, ST_KEY, ST_BRD, ST_BPROC, ST_BWR, ST_DONE
  } fcc_state_e;

  typedef enum logic [1:0] {
    KSZ_128 = 2'd0, KSZ_192 = 2'd1, KSZ_256 = 2'd2, KSZ_BAD = 2'd3
  } key_size_e;
endpackage

// File: rtl/fcc_cnt.sv
module fcc_cnt #(
  parameter int W    = 4,
  parameter int LAST = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] val,
  output logic         at_last
);
  assign at_last = (val == W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                val <= '0;
    else if (clr)              val <= '0;
    else if (en && !at_last)   val <= val + 1'b1;
  end
endmodule

// File: rtl/fcc_hdr_decode.sv
module fcc_hdr_decode #(
  parameter int LEN_W = 8,
  parameter int CAP   = 253
) (
  input  logic [1:0]       code,
  input  logic [LEN_W-1:0] len,
  output logic             code_ok,
  output logic             len_ok,
  output logic             empty
);
  import fcc_pkg::*;
  always_comb begin
    code_ok = (key_size_e'(code) != KSZ_BAD);
    len_ok  = (int'(len) <= CAP);
    empty   = (len == '0);
  end
endmodule

// File: rtl/fcc_blk_walk.sv
module fcc_blk_walk #(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  count,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [LEN_W-1:0] remain;
  assign last = (remain == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      remain <= '0;
    end else if (load) begin
      addr   <= base;
      remain <= count;
    end else if (step) begin
      addr   <= addr + 1'b1;
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/frame_cipher_ctrl.sv
module frame_cipher_ctrl #(
  parameter int ADDR_W  = 8,
  parameter int BLK_W   = 128,
  parameter int KEY_CYC = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                mem_rd_en,
  output logic                mem_wr_en,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BLK_W-1:0]    mem_wdata,
  input  logic [BLK_W-1:0]    mem_rdata,
  output logic                key_load,
  output logic [2*BLK_W-1:0]  key_val,
  output logic [1:0]          key_sel,
  output logic                decrypt,
  output logic                cph_start,
  output logic [BLK_W-1:0]    cph_din,
  input  logic                cph_done,
  input  logic [BLK_W-1:0]    cph_dout
);
  import fcc_pkg::*;

  localparam int CAP   = (1 << ADDR_W) - HDR_BLKS;
  localparam int KCW   = $clog2(KEY_CYC);
  localparam int HCW   = $clog2(HDR_BLKS + 1);

  fcc_state_e st, st_nx;

  logic [BLK_W-1:0] key_lo, key_hi, res_q;
  logic [1:0]       code_q;
  logic             dec_q, launch_q, err_q;
  logic [LEN_W-1:0] len_q;

  logic [HCW-1:0]   hval;
  logic             h_last;
  logic [KCW-1:0]   kval;
  logic             k_last;
  logic             code_ok, len_ok, empty;
  logic [ADDR_W-1:0] blk_addr;
  logic             blk_last;
  logic             go;

  assign go = (st == ST_IDLE) && start;

  fcc_cnt #(.W(HCW), .LAST(HDR_BLKS)) u_hdr_cnt (
    .clk(clk), .rst_n(rst_n), .clr(go), .en(st == ST_HDR),
    .val(hval), .at_last(h_last)
  );

  fcc_cnt #(.W(KCW), .LAST(KEY_CYC-1)) u_key_cnt (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_DEC), .en(st == ST_KEY),
    .val(kval), .at_last(k_last)
  );

  fcc_hdr_decode #(.LEN_W(LEN_W), .CAP(CAP)) u_dec (
    .code(code_q), .len(len_q),
    .code_ok(code_ok), .len_ok(len_ok), .empty(empty)
  );

  fcc_blk_walk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .load(st == ST_DEC), .base(ADDR_W'(HDR_BLKS)), .count(len_q),
    .step(st == ST_BWR), .addr(blk_addr), .last(blk_last)
  );

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:  if (start) st_nx = ST_HDR;
      ST_HDR:   if (h_last) st_nx = ST_DEC;
      ST_DEC: begin
        if (!code_ok || !len_ok || empty) st_nx = ST_DONE;
        else                              st_nx = ST_KEY;
      end
      ST_KEY:   if (k_last) st_nx = ST_BRD;
      ST_BRD:   st_nx = ST_BPROC;
      ST_BPROC: if (cph_done) st_nx = ST_BWR;
      ST_BWR:   st_nx = blk_last ? ST_DONE : ST_BRD;
      ST_DONE:  st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      key_lo   <= '0;
      key_hi   <= '0;
      code_q   <= '0;
      dec_q    <= 1'b0;
      len_q    <= '0;
      res_q    <= '0;
      launch_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st       <= st_nx;
      launch_q <= (st == ST_BRD);
      if (go) err_q <= 1'b0;
      if (st == ST_HDR) begin
        if (hval == HCW'(1)) key_lo <= mem_rdata;
        if (hval == HCW'(2)) key_hi <= mem_rdata;
        if (h_last) begin
          code_q <= mem_rdata[KCODE_LSB +: KCODE_W];
          dec_q  <= mem_rdata[MODE_BIT];
          len_q  <= mem_rdata[LEN_LSB +: LEN_W];
        end
      end
      if (st == ST_DEC && (!code_ok || !len_ok)) err_q <= 1'b1;
      if (st == ST_BPROC && cph_done) res_q <= cph_dout;
    end
  end

  always_comb begin
    mem_addr = blk_addr;
    if (st == ST_HDR) mem_addr = ADDR_W'(hval);
  end

  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_DONE);
  assign err       = err_q;
  assign mem_rd_en = ((st == ST_HDR) && !h_last) || (st == ST_BRD);
  assign mem_wr_en = (st == ST_BWR);
  assign mem_wdata = res_q;
  assign key_load  = (st == ST_KEY) && (kval == '0);
  assign key_val   = {key_hi, key_lo};
  assign key_sel   = code_q;
  assign decrypt   = dec_q;
  assign cph_start = (st == ST_BPROC) && launch_q;
  assign cph_din   = mem_rdata;
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              key_load,
  input logic              cph_start,
  input logic              cph_done
);
  logic [ADDR_W-1:0] last_rd;
  logic              key_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_rd  <= '0;
      key_seen <= 1'b0;
    end else begin
      if (mem_rd_en) last_rd <= mem_addr;
      if (key_load)  key_seen <= 1'b1;
      else if (done) key_seen <= 1'b0;
    end
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_WR_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> $past(cph_done)); // R4
  AST_WR_IN_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (mem_addr == last_rd)); // R5
  AST_KEY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cph_start |-> key_seen); // R3
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done); // R8
  AST_NO_REENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R9
endmodule

bind frame_cipher_ctrl fcc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
  .key_load(key_load), .cph_start(cph_start), .cph_done(cph_done)
);

// File: tb/frame_cipher_ctrl_bench.sv
module frame_cipher_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] code;
    logic       dec;
    logic [7:0] len;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 1'b0, 8'd1,   8'h11},
    '{2'd1, 1'b1, 8'd3,   8'h22},
    '{2'd2, 1'b0, 8'd2,   8'h33},
    '{2'd3, 1'b0, 8'd2,   8'h44},
    '{2'd0, 1'b1, 8'd0,   8'h55},
    '{2'd0, 1'b0, 8'd254, 8'h66},
    '{2'd2, 1'b1, 8'd253, 8'h77}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, err, mem_rd_en, mem_wr_en, key_load, decrypt, cph_start, cph_done;
  logic [7:0]   mem_addr;
  logic [127:0] mem_wdata, mem_rdata, cph_din, cph_dout;
  logic [255:0] key_val;
  logic [1:0]   key_sel;

  logic         tb_we = 1'b0;
  logic [7:0]   tb_addr = '0;
  logic [127:0] tb_data = '0;
  logic [127:0] ram [256];

  int n_checks = 0, n_fail = 0;
  int n_wr = 0, n_kl = 0, n_done = 0;
  logic [1:0] seen_sel;
  logic       seen_dec;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_cipher_ctrl u_frame_cipher_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .err(err),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .key_load(key_load),
    .key_val(key_val), .key_sel(key_sel), .decrypt(decrypt),
    .cph_start(cph_start), .cph_din(cph_din), .cph_done(cph_done), .cph_dout(cph_dout)
  );

  function automatic logic [127:0] stub_f(input logic [255:0] k, input logic [1:0] sel,
                                          input logic d, input logic [127:0] x);
    logic [127:0] kk;
    kk = k[127:0] ^ ((sel != 2'd0) ? k[255:128] : 128'd0);
    return d ? (x - kk) : (x + kk);
  endfunction

  // RAM model: one-cycle read latency
  always @(posedge clk) begin
    if (tb_we) ram[tb_addr] <= tb_data;
    else if (mem_wr_en) ram[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= ram[mem_addr];
  end

  // Cipher stand-in: result ten cycles after launch
  logic [255:0] sk;
  logic [1:0]   ssel;
  logic         sdec;
  logic [3:0]   scnt;
  logic [127:0] sout;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk <= '0; ssel <= '0; sdec <= 1'b0; scnt <= '0; sout <= '0;
    end else begin
      if (key_load) begin sk <= key_val; ssel <= key_sel; sdec <= decrypt; end
      if (cph_start) begin scnt <= 4'd1; sout <= stub_f(sk, ssel, sdec, cph_din); end
      else if (scnt == 4'd10) scnt <= 4'd0;
      else if (scnt != 4'd0) scnt <= scnt + 4'd1;
    end
  end
  assign cph_done = (scnt == 4'd10);
  assign cph_dout = sout;

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_wr_en) n_wr++;
      if (key_load) begin n_kl++; seen_sel = key_sel; seen_dec = decrypt; end
      if (done) n_done++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic load_blk(input int a, input logic [127:0] d);
    @(negedge clk); tb_we = 1'b1; tb_addr = 8'(a); tb_data = d;
    @(negedge clk); tb_we = 1'b0;
  endtask

  function automatic logic [127:0] dpat(input logic [7:0] seed, input int i);
    return {4{seed, 8'(i), 16'hA5C3}};
  endfunction

  task automatic run(input vec_t v, input int poke);
    int nload, b_wr, b_kl, b_dn, cyc, exp_cyc;
    bit bad, proc, all_ok;
    logic [127:0] kl, kh, ctrl, e, a_bad, e_bad;
    string tag;
    bad  = (v.code == 2'd3) || (v.len > 8'd253);
    proc = !bad && (v.len != 8'd0);
    nload = (v.len > 8'd253) ? 4 : int'(v.len);
    if (nload == 0) nload = 1;
    kl = {8{v.seed, 8'h5A}};
    kh = {8{v.seed ^ 8'hFF, 8'hC3}};
    ctrl = '0; ctrl[1:0] = v.code; ctrl[4] = v.dec; ctrl[23:16] = v.len;
    load_blk(0, kl); load_blk(1, kh); load_blk(2, ctrl);
    for (int i = 0; i < nload; i++) load_blk(3 + i, dpat(v.seed, i));
    if (3 + nload < 256) load_blk(3 + nload, {4{32'hDEAD_BEEF}});
    b_wr = n_wr; b_kl = n_kl; b_dn = n_dn_get();
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    chk(err == 1'b0, "R8 err cleared by start", 128'(err), 128'd0);
    chk(busy == 1'b1, "R9 busy after start", 128'(busy), 128'd1);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk); cyc++;
      @(negedge clk); start = (cyc == poke);
    end
    start = 1'b0;
    exp_cyc = proc ? 16 + 13 * int'(v.len) : 5;
    tag = proc ? "R4 frame timing" : (bad ? "R8 error timing" : "R7 empty timing");
    chk(cyc == exp_cyc, tag, 128'(cyc), 128'(exp_cyc));
    chk(err == bad, "R8 err flag", 128'(err), 128'(bad));
    @(negedge clk);
    chk(done == 1'b0, "R6 done single pulse", 128'(done), 128'd0);
    chk(n_dn_get() - b_dn == 1, "R6 one done", 128'(n_dn_get() - b_dn), 128'd1);
    chk(n_wr - b_wr == (proc ? int'(v.len) : 0), "R5 write count",
        128'(n_wr - b_wr), 128'(proc ? int'(v.len) : 0));
    chk(n_kl - b_kl == int'(proc), "R3 key load count", 128'(n_kl - b_kl), 128'(proc));
    if (proc) begin
      chk(seen_sel == v.code, "R2 key size", 128'(seen_sel), 128'(v.code));
      chk(seen_dec == v.dec, "R2 direction", 128'(seen_dec), 128'(v.dec));
    end
    all_ok = 1'b1; a_bad = '0; e_bad = '0;
    for (int i = 0; i < nload; i++) begin
      e = proc ? stub_f({kh, kl}, v.code, v.dec, dpat(v.seed, i)) : dpat(v.seed, i);
      if (ram[3 + i] !== e && all_ok) begin all_ok = 1'b0; a_bad = ram[3 + i]; e_bad = e; end
    end
    chk(all_ok, "R5 in-place results", a_bad, e_bad);
    if (3 + nload < 256)
      chk(ram[3 + nload] == {4{32'hDEAD_BEEF}}, "R5 sentinel untouched",
          ram[3 + nload], {4{32'hDEAD_BEEF}});
    @(negedge clk);
    chk(err == bad, "R8 err held", 128'(err), 128'(bad));
  endtask

  function automatic int n_dn_get();
    return n_done;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R4 watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, err, mem_rd_en, mem_wr_en, key_load, cph_start} == '0,
        "R1 state in reset", 128'({busy, done, err, mem_rd_en, mem_wr_en, key_load, cph_start}), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, err, mem_rd_en, mem_wr_en, key_load, cph_start} == '0,
        "R1 idle after reset", 128'({busy, done, err, mem_rd_en, mem_wr_en, key_load, cph_start}), 128'd0);
    for (int k = 0; k < 7; k++) run(VECS[k], -1);
    // R9: start pulses mid-frame are ignored
    run('{2'd1, 1'b0, 8'd2, 8'h99}, 20);
    run('{2'd0, 1'b1, 8'd1, 8'hA7}, 3);
    summary();
  end
endmodule